// File: doc/BRIEF.md
# Two-Device Clock Synthesizer Configuration Sequencer

This block brings up two clock-synthesizer chips after power-up by writing each one a fixed table of ten 32-bit register words over a write-only serial link. A single `start` pulse launches the whole sequence. The block writes the first chip's setup words in table order and then writes the control word that holds calibration disabled in manual mode. It then pauses for a programmable settling interval so the reference oscillator can become stable, and writes the final word that sets calibration-enable to begin manual calibration. After that it waits for the first chip to report lock.

Only once that lock is seen does the second chip receive anything, and it is configured the same way. Each lock input is a slow level from the chip, so it passes through a two-flop synchronizer before the sequencer acts on it. If lock does not arrive within a set number of cycles, the sequence ends with a timeout flag and the serial link falls silent. `done` rises only when the second chip has locked after its calibration write.

Top module: `pll_cfg_seq`

## Requirements
- R1: Out of reset `busy`, `done` and `timeout` are low, both chip selects are high and `sclk` is low.
- R2: Each chip receives ten words in index order 0 to 9. Word k < 8 of chip d is {8'hC0+d, 4'h0, k[3:0], 16'h5A5A}. Word 8 is 32'h8000_0006 with bit 8 equal to d, which has the manual-mode bit 31 set and the calibration-enable bit 26 clear. Word 9 is word 8 with bit 26 set.
- R3: During a word the chip select is low for exactly 32 rising edges of `sclk`. Data is sent MSB first and `mosi` does not change while `sclk` is high. `sclk` is low whenever its select is high. Between two words the selects are high for at least one full `sclk` period (2*SCLK_HALF clocks).
- R4: Each high phase of `sclk` lasts SCLK_HALF system clocks. The default of 4 clocks at 125 MHz keeps the serial clock below 20 MHz.
- R5: For each chip, at least CLK_MHZ*SETTLE_US system clocks pass between the end of word 8 and the start of word 9.
- R6: The second chip's select stays high until the synchronized lock of the first chip has been seen. The two selects are never low together.
- R7: If the awaited lock does not appear within LOCK_WAIT clocks after the calibration word, `timeout` rises, `busy` falls and no further word is sent.
- R8: `done` rises only after the second chip's word 9 has been sent and its lock is high. `done` and `busy` are never high together.
- R9: A `start` pulse while `busy` is high has no effect: each chip still receives exactly ten words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches the configuration sequence |
| lock0 | input | 1 | Lock indication of the first chip (asynchronous level) |
| lock1 | input | 1 | Lock indication of the second chip (asynchronous level) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Both chips configured and locked |
| timeout | output | 1 | A lock wait expired |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data, MSB first |
| cs0_n | output | 1 | Active-low select of the first chip |
| cs1_n | output | 1 | Active-low select of the second chip |

## Verification
The in-line assertions check several properties on every cycle: the data line holds while the serial clock is high, and the clock is idle whenever the select is high. They also check that the second select can only fall after the first chip's lock has been seen, that `done` and `timeout` are never raised while `busy` is high, and that `done` rises only after a synchronized lock. Other properties span many cycles and can only be shown by the bench scenarios: the content and order of all twenty words, the width of the settle gap before each calibration word, the serial clock period, the effect of a stray start pulse, and the outcome when either chip fails to lock.

// File: rtl/pll_cfg_pkg.sv
// Shared types and the configuration word tables for the sequencer.
// Assumes ten words per chip, with the calibration trigger as the last one.
package pll_cfg_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 10;
    localparam int CAL_IDX   = NUM_WORDS - 1;   // index of calibration-start word
    localparam int CTRL_IDX  = NUM_WORDS - 2;   // index of calibration-hold word
    localparam int IDX_W     = $clog2(NUM_WORDS);

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SEND,
        SEQ_WAIT_TX,
        SEQ_SETTLE,
        SEQ_LOCK
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SHIFT,
        TX_GAP
    } tx_state_t;

    // Word k of chip dev; the last two words rewrite the control register.
    function automatic logic [WORD_W-1:0] cfg_word(input logic dev, input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] w;
        if (int'(idx) < CTRL_IDX)
            w = {8'hC0 + {7'd0, dev}, 4'h0, idx, 16'h5A5A};
        else begin
            w = 32'h8000_0006 | {23'd0, dev, 8'd0};
            if (int'(idx) == CAL_IDX)
                w = w | 32'h0400_0000;
        end
        return w;
    endfunction

endpackage

// File: rtl/pll_cfg_rom.sv
// Two constant tables of configuration words, one per chip, selected by
// chip number and word index. Purely combinational.
module pll_cfg_rom
    import pll_cfg_pkg::*;
(
    input  logic              dev,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] table_q [2][NUM_WORDS];

    // Build both tables from the package word function.
    for (genvar d = 0; d < 2; d++) begin : g_dev
        for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
            assign table_q[d][i] = cfg_word(1'(d), IDX_W'(i));
        end
    end

    // Select the requested word; out-of-range index reads zero.
    always_comb begin
        word = '0;
        if (int'(idx) < NUM_WORDS)
            word = table_q[dev][idx];
    end

endmodule

// File: rtl/lock_sync.sv
// Two-flop synchronizer for slow asynchronous level inputs.
// Assumes inputs stay stable far longer than two clock periods.
module lock_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic meta_q, sync_q;
        // Two-stage resynchronisation of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                sync_q <= meta_q;
            end
        end
        assign sync_out[g] = sync_q;
    end

endmodule

// File: rtl/spi_word_tx.sv
// Write-only serial transmitter for one 32-bit word: select low, MSB first,
// data changed on falling sclk, then a select-high gap of one sclk period.
// Assumes start is only given while the transmitter is idle.
module spi_word_tx
    import pll_cfg_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              done
);

    localparam int GAP_CYC = 2 * SCLK_HALF;
    localparam int DIV_W   = $clog2(GAP_CYC + 1);
    localparam int BIT_W   = $clog2(WORD_W);

    tx_state_t         st_q;
    logic [WORD_W-1:0] sh_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;

    assign mosi = sh_q[WORD_W-1];

    // Shift engine: load, toggle sclk every SCLK_HALF clocks, then gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            sh_q  <= '0;
            div_q <= '0;
            bit_q <= '0;
            sclk  <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                TX_IDLE: if (start) begin
                    sh_q  <= word;
                    cs_n  <= 1'b0;
                    div_q <= '0;
                    bit_q <= '0;
                    st_q  <= TX_SHIFT;
                end
                TX_SHIFT: begin
                    if (div_q == DIV_W'(SCLK_HALF - 1)) begin
                        div_q <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (bit_q == BIT_W'(WORD_W - 1)) begin
                                cs_n <= 1'b1;
                                st_q <= TX_GAP;
                            end else begin
                                sh_q  <= sh_q << 1;
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (div_q == DIV_W'(GAP_CYC - 1)) begin
                        done <= 1'b1;
                        st_q <= TX_IDLE;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));   // R3

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);   // R3

endmodule

// File: rtl/pll_cfg_seq.sv
// Configures two clock-synthesizer chips in turn: ten words each, a settle
// wait before the calibration word, then a lock wait with timeout. The
// second chip is only written after the first chip has locked.
// Assumes lock inputs are slow levels and that start is a single pulse.
module pll_cfg_seq
    import pll_cfg_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int SETTLE_US = 200,
    parameter int LOCK_WAIT = 1_000_000,
    parameter int SCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic lock0,
    input  logic lock1,
    output logic busy,
    output logic done,
    output logic timeout,
    output logic sclk,
    output logic mosi,
    output logic cs0_n,
    output logic cs1_n
);

    localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
    localparam int CNT_MAX    = (SETTLE_CYC > LOCK_WAIT) ? SETTLE_CYC : LOCK_WAIT;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    seq_state_t        st_q;
    logic              dev_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              lock0_seen_q;
    logic [1:0]        lock_s;
    logic [WORD_W-1:0] word;
    logic              tx_start, tx_done, tx_cs_n;

    lock_sync #(.N(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({lock1, lock0}),
        .sync_out (lock_s)
    );

    pll_cfg_rom u_rom (
        .dev  (dev_q),
        .idx  (idx_q),
        .word (word)
    );

    spi_word_tx #(.SCLK_HALF(SCLK_HALF)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .word  (word),
        .sclk  (sclk),
        .mosi  (mosi),
        .cs_n  (tx_cs_n),
        .done  (tx_done)
    );

    assign tx_start = (st_q == SEQ_SEND);
    assign busy     = (st_q != SEQ_IDLE);
    assign cs0_n    = dev_q ? 1'b1 : tx_cs_n;
    assign cs1_n    = dev_q ? tx_cs_n : 1'b1;

    // Sequencing FSM: words, settle wait, lock wait, chip hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= SEQ_IDLE;
            dev_q        <= 1'b0;
            idx_q        <= '0;
            cnt_q        <= '0;
            lock0_seen_q <= 1'b0;
            done         <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: if (start) begin
                    dev_q        <= 1'b0;
                    idx_q        <= '0;
                    lock0_seen_q <= 1'b0;
                    done         <= 1'b0;
                    timeout      <= 1'b0;
                    st_q         <= SEQ_SEND;
                end
                SEQ_SEND: st_q <= SEQ_WAIT_TX;
                SEQ_WAIT_TX: if (tx_done) begin
                    cnt_q <= '0;
                    if (int'(idx_q) == CTRL_IDX) begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= SEQ_SETTLE;
                    end else if (int'(idx_q) == CAL_IDX) begin
                        st_q <= SEQ_LOCK;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= SEQ_SEND;
                    end
                end
                SEQ_SETTLE: begin
                    if (cnt_q >= CNT_W'(SETTLE_CYC - 1))
                        st_q <= SEQ_SEND;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                SEQ_LOCK: begin
                    if (lock_s[dev_q]) begin
                        if (!dev_q) begin
                            dev_q        <= 1'b1;
                            idx_q        <= '0;
                            lock0_seen_q <= 1'b1;
                            st_q         <= SEQ_SEND;
                        end else begin
                            done <= 1'b1;
                            st_q <= SEQ_IDLE;
                        end
                    end else if (cnt_q >= CNT_W'(LOCK_WAIT - 1)) begin
                        timeout <= 1'b1;
                        st_q    <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs0_n && !cs1_n));   // R6

    AST_DEV2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs1_n |-> lock0_seen_q);   // R6

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !busy);   // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);   // R8

    AST_DONE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(lock_s[1]));   // R8

endmodule

// File: tb/pll_cfg_seq_test.sv
// Bench: behavioural model decodes the serial link each clock, drives lock
// responses, and compares words, timing and status against the requirements.
module pll_cfg_seq_test;

    localparam int HALF      = 4;
    localparam int CLK_MHZ   = 125;
    localparam int SETTLE_US = 2;
    localparam int SETTLE    = CLK_MHZ * SETTLE_US;
    localparam int LOCK_WAIT = 3000;
    localparam int LOCK_DLY  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] lock = 2'b00;
    logic busy, done, timeout, sclk, mosi, cs0_n, cs1_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pll_cfg_seq #(
        .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US),
        .LOCK_WAIT(LOCK_WAIT), .SCLK_HALF(HALF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .lock0(lock[0]), .lock1(lock[1]),
        .busy(busy), .done(done), .timeout(timeout),
        .sclk(sclk), .mosi(mosi), .cs0_n(cs0_n), .cs1_n(cs1_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word table, written from the encoding stated in R2.
    function automatic logic [31:0] exp_word(input int d, input int k);
        logic [31:0] w;
        if (k < 8) w = {8'hC0 + 8'(d), 4'h0, 4'(k), 16'h5A5A};
        else begin
            w = 32'h8000_0006 | (32'(d) << 8);
            if (k == 9) w = w | 32'h0400_0000;
        end
        return w;
    endfunction

    // Behavioural model state
    bit         allow [2];
    int         nwords [2];
    int         nbits;
    logic [31:0] cap;
    int         cyc, last_rise, end8 [2], hi_cnt, lock0_hi, lk_cnt [2];
    logic       p_sclk, p_done;
    logic [1:0] p_cs;

    task automatic model_clear();
        for (int d = 0; d < 2; d++) begin
            nwords[d] = 0; end8[d] = 0; lk_cnt[d] = 0;
        end
        nbits = 0; cap = '0; cyc = 0; last_rise = -1; hi_cnt = 0; lock0_hi = 0;
        p_sclk = 1'b0; p_done = 1'b0; p_cs = 2'b11;
    endtask

    // Per-clock comparison, sampled away from the active edge.
    always @(negedge clk) begin
        logic [1:0] cs;
        cs = {cs1_n, cs0_n};
        if (rst_n) begin
            cyc++;
            chk(cs != 2'b00, "R6 selects exclusive", cs, 2'b01);
            chk(!(done && busy), "R8 done excludes busy", {done, busy}, 2'b10);
            if (lock[0]) lock0_hi++;
            for (int d = 0; d < 2; d++) begin
                if (p_cs[d] && !cs[d]) begin
                    nbits = 0; cap = '0;
                    if (last_rise >= 0)
                        chk(cyc - last_rise >= 2 * HALF, "R3 inter-word gap", cyc - last_rise, 2 * HALF);
                    if (nwords[d] == 9)
                        chk(cyc - end8[d] >= SETTLE, "R5 settle before calibration", cyc - end8[d], SETTLE);
                    if (d == 1 && nwords[1] == 0)
                        chk(lock0_hi >= 2, "R6 second chip after lock", lock0_hi, 2);
                end
                if (!p_cs[d] && cs[d]) begin
                    chk(nbits == 32, "R3 edges per word", nbits, 32);
                    chk(cap == exp_word(d, nwords[d]), "R2 word content", cap, exp_word(d, nwords[d]));
                    nwords[d]++;
                    last_rise = cyc;
                    if (nwords[d] == 9) end8[d] = cyc;
                    if (nwords[d] == 10 && allow[d]) lk_cnt[d] = LOCK_DLY;
                end
                if (lk_cnt[d] > 0) begin
                    lk_cnt[d]--;
                    if (lk_cnt[d] == 0) lock[d] = 1'b1;
                end
            end
            if (cs != 2'b11 && !p_sclk && sclk) begin
                nbits++;
                cap = {cap[30:0], mosi};
            end
            if (sclk) hi_cnt++;
            if (p_sclk && !sclk) begin
                chk(hi_cnt == HALF, "R4 sclk high phase", hi_cnt, HALF);
                hi_cnt = 0;
            end
            if (!p_done && done)
                chk(lock[1] && nwords[1] == 10, "R8 done after second lock", {lock[1], 8'(nwords[1])}, {1'b1, 8'd10});
            p_sclk = sclk; p_cs = cs; p_done = done;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lock = 2'b00; start = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle(input int maxc);
        int n = 0;
        @(negedge clk);
        while (busy && n < maxc) begin @(negedge clk); n++; end
        chk(!busy, "R7 sequence ends", busy, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        allow[0] = 1'b1; allow[1] = 1'b1;
        do_reset();
        // R1: reset state
        @(negedge clk);
        chk(!busy && !done && !timeout, "R1 status after reset", {busy, done, timeout}, 0);
        chk(cs0_n && cs1_n && !sclk, "R1 link idle after reset", {cs0_n, cs1_n, sclk}, 3'b110);

        // Normal bring-up with a stray start pulse mid-run (R9)
        pulse_start();
        repeat (300) @(negedge clk);
        pulse_start();
        wait_idle(60000);
        chk(done && !timeout, "R8 done after full run", {done, timeout}, 2'b10);
        chk(nwords[0] == 10, "R9 first chip word count", nwords[0], 10);
        chk(nwords[1] == 10, "R9 second chip word count", nwords[1], 10);
        repeat (100) @(negedge clk);
        chk(nwords[0] + nwords[1] == 20 && cs0_n && cs1_n, "R9 no extra words", nwords[0] + nwords[1], 20);

        // First chip never locks: timeout, second chip untouched (R6, R7)
        allow[0] = 1'b0; allow[1] = 1'b1;
        do_reset();
        pulse_start();
        wait_idle(60000);
        chk(timeout && !done, "R7 timeout on first lock", {timeout, done}, 2'b10);
        chk(nwords[1] == 0, "R6 second chip untouched", nwords[1], 0);
        lock[0] = 1'b1;
        repeat (300) @(negedge clk);
        chk(nwords[0] == 10 && nwords[1] == 0 && !busy, "R7 silent after timeout", nwords[0] + nwords[1], 10);

        // Second chip never locks: timeout, no done (R7, R8)
        allow[0] = 1'b1; allow[1] = 1'b0;
        do_reset();
        pulse_start();
        wait_idle(60000);
        chk(timeout && !done, "R8 no done without second lock", {timeout, done}, 2'b10);
        chk(nwords[1] == 10, "R2 second chip got full table", nwords[1], 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule